// File: doc/BRIEF.md
# Multiplexed External Memory Bus Master

This block lets an 8-bit controller reach external memory and I/O devices over a shared address/data port. One internal request carries an address, write data, a direction, a memory-space select and an extended-timing flag. The block turns it into one framed bus cycle. First the low address byte goes onto the shared port and an active-low address strobe pulses, so that external logic can latch the address. The port is then released. An active-low data strobe frames the data transfer. A direction line and a data-memory select line stay steady across the whole cycle.

Every interval is a whole number of system clocks, and each interval is a parameter. Reads hold the data strobe low longer than writes. The extended-timing flag adds further clocks to the data strobe. The upper address bits sit on their own output for the whole cycle. A read returns the byte sampled at the clock edge where the data strobe rises. A one-clock done pulse closes each access. A new request is taken only while the block is idle.

Top module: `xbus_master`

## Requirements
- R1: Out of reset and whenever idle, `bus_as_n` and `bus_ds_n` are 1, `bus_ad_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: After a request is accepted, the port drives `req_addr[PORT_W-1:0]` for T_SETUP clocks with `bus_as_n` high. It keeps driving the address for T_ASLO further clocks with `bus_as_n` low.
- R3: For T_FLOAT clocks after `bus_as_n` rises, both strobes are high and the address is no longer on the port. On a read, `bus_ad_oe` stays 0 from then until the cycle ends. `bus_ds_n` is never low while `bus_as_n` is low.
- R4: On a write, `bus_ds_n` is low for T_WR clocks. The port drives the write data, with `bus_ad_oe` at 1, from the float interval through the recovery interval.
- R5: On a read, `bus_ds_n` is low for T_RD clocks. `rsp_rdata` holds the value of `bus_ad_in` sampled at the clock edge where `bus_ds_n` returns high.
- R6: When `req_ext` is 1, the `bus_ds_n` low time grows by T_EXT clocks, for both reads and writes.
- R7: `bus_rw` is 1 for a read and 0 for a write. It is valid from the first clock of the cycle and does not change until the cycle ends.
- R8: `bus_dm_n` is 0 when `req_dmem` is 1 and 1 otherwise. It is valid from the first clock of the cycle, before `bus_as_n` falls, and holds until the cycle ends. When idle it is 1.
- R9: `rsp_done` is 1 for exactly one clock: the recovery clock (T_REC=1) that follows the rising edge of `bus_ds_n`. The block is idle on the next clock. While busy, `req_ready` is 0, and any request, whatever its field values, has no effect on the cycle in progress.
- R10: `bus_addr_hi` carries `req_addr[ADDR_W-1:PORT_W]` through the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken at this edge |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | PORT_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | 1 = data-memory space |
| req_ext | input | 1 | 1 = extended data strobe |
| rsp_rdata | output | PORT_W | Byte captured by the last read |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| bus_ad_out | output | PORT_W | Shared port output value |
| bus_ad_oe | output | 1 | Shared port drive enable |
| bus_ad_in | input | PORT_W | Shared port input value |
| bus_addr_hi | output | ADDR_W-PORT_W | Upper address bits |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dm_n | output | 1 | Data-memory select, active low |

## Verification
The bench builds the block with ADDR_W=12, which leaves 4 upper address bits, and keeps the default phase lengths: 1 clock for setup, strobe, float and recovery; 3 for a read and 2 for a write; 2 extra when extended. With these values one access lasts 6 to 9 clocks. Every read/write and normal/extended combination, and every value of the upper address bits, comes up many times in a few hundred random accesses. The shared-port input changes on every clock of a read, so a capture made one edge early or late shows up as a wrong byte. During some accesses conflicting requests are held on the inputs to show that they are ignored.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_ASLO  = 3'd2,
      PH_FLOAT = 3'd3,
      PH_DATA  = 3'd4,
      PH_REC   = 3'd5
   } xbus_phase_e;
endpackage

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [PORT_W-1:0] in_wdata,
   input  logic              in_write,
   input  logic              in_dmem,
   input  logic              in_ext,
   output logic [ADDR_W-1:0] h_addr,
   output logic [PORT_W-1:0] h_wdata,
   output logic              h_write,
   output logic              h_dmem,
   output logic              h_ext
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_addr  <= '0;
         h_wdata <= '0;
         h_write <= 1'b0;
         h_dmem  <= 1'b0;
         h_ext   <= 1'b0;
      end else if (load) begin
         h_addr  <= in_addr;
         h_wdata <= in_wdata;
         h_write <= in_write;
         h_dmem  <= in_dmem;
         h_ext   <= in_ext;
      end
   end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int T_SETUP = 1,
   parameter int T_ASLO  = 1,
   parameter int T_FLOAT = 1,
   parameter int T_RD    = 3,
   parameter int T_WR    = 2,
   parameter int T_EXT   = 2,
   parameter int T_REC   = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        is_write,
   input  logic        is_ext,
   output xbus_phase_e phase,
   output logic        last
);
   localparam int SUM_T = T_SETUP + T_ASLO + T_FLOAT + T_RD + T_WR + T_EXT + T_REC;
   localparam int CNT_W = $clog2(SUM_T + 1);

   logic [CNT_W-1:0] cnt;
   int               data_len;

   always_comb begin
      data_len = (is_write ? T_WR : T_RD) + (is_ext ? T_EXT : 0);
   end

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         if (phase == PH_IDLE) begin
            if (start) begin
               phase <= PH_SETUP;
               cnt   <= CNT_W'(T_SETUP - 1);
            end
         end else if (!last) begin
            cnt <= cnt - 1'b1;
         end else begin
            unique case (phase)
               PH_SETUP: begin phase <= PH_ASLO;  cnt <= CNT_W'(T_ASLO - 1);  end
               PH_ASLO:  begin phase <= PH_FLOAT; cnt <= CNT_W'(T_FLOAT - 1); end
               PH_FLOAT: begin phase <= PH_DATA;  cnt <= CNT_W'(data_len - 1); end
               PH_DATA:  begin phase <= PH_REC;   cnt <= CNT_W'(T_REC - 1);   end
               default:  begin phase <= PH_IDLE;  cnt <= '0;                  end
            endcase
         end
      end
   end

   // R6: the data strobe counter never starts above the longest allowed data phase
   assert_data_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) |-> (int'(cnt) < T_EXT + ((T_RD > T_WR) ? T_RD : T_WR)));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int PORT_W        = 8,
   parameter bit DM_ACTIVE_LOW = 1'b1
) (
   input  xbus_phase_e              phase,
   input  logic [ADDR_W-1:0]        h_addr,
   input  logic [PORT_W-1:0]        h_wdata,
   input  logic                     h_write,
   input  logic                     h_dmem,
   output logic [PORT_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-PORT_W-1:0] addr_hi,
   output logic                     as_n,
   output logic                     ds_n,
   output logic                     rw,
   output logic                     dm_sel
);
   logic busy;
   logic addr_ph;
   logic dm_act;

   assign busy    = (phase != PH_IDLE);
   assign addr_ph = (phase == PH_SETUP) || (phase == PH_ASLO);
   assign as_n    = (phase != PH_ASLO);
   assign ds_n    = (phase != PH_DATA);
   assign rw      = busy ? !h_write : 1'b1;
   assign ad_oe   = addr_ph || (h_write && (phase == PH_FLOAT || phase == PH_DATA || phase == PH_REC));
   assign ad_out  = addr_ph ? h_addr[PORT_W-1:0] : h_wdata;
   assign addr_hi = h_addr[ADDR_W-1:PORT_W];
   assign dm_act  = busy && h_dmem;

   generate
      if (DM_ACTIVE_LOW) begin : g_dm_low
         assign dm_sel = !dm_act;
      end else begin : g_dm_high
         assign dm_sel = dm_act;
      end
   endgenerate

   // R3: the data strobe is never low together with the address strobe
   always_comb begin
      assert_strobe_excl_R3: assert (!((phase != PH_IDLE) && !ds_n && !as_n));
   end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grab,
   input  logic [PORT_W-1:0] din,
   output logic [PORT_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (grab) dout <= din;
   end
endmodule

// File: rtl/xbus_master.sv
module xbus_master
   import xbus_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int PORT_W        = 8,
   parameter int T_SETUP       = 1,
   parameter int T_ASLO        = 1,
   parameter int T_FLOAT       = 1,
   parameter int T_RD          = 3,
   parameter int T_WR          = 2,
   parameter int T_EXT         = 2,
   parameter int T_REC         = 1,
   parameter bit DM_ACTIVE_LOW = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [PORT_W-1:0]        req_wdata,
   input  logic                     req_write,
   input  logic                     req_dmem,
   input  logic                     req_ext,
   output logic [PORT_W-1:0]        rsp_rdata,
   output logic                     rsp_done,
   output logic [PORT_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   input  logic [PORT_W-1:0]        bus_ad_in,
   output logic [ADDR_W-PORT_W-1:0] bus_addr_hi,
   output logic                     bus_as_n,
   output logic                     bus_ds_n,
   output logic                     bus_rw,
   output logic                     bus_dm_n
);
   localparam int HI_W = ADDR_W - PORT_W;

   initial begin
      assert (PORT_W >= 1 && HI_W >= 1) else $error("ADDR_W must exceed PORT_W");
      assert (T_SETUP >= 1 && T_ASLO >= 1 && T_FLOAT >= 1 && T_REC >= 1)
         else $error("every framing interval needs at least one clock");
      assert (T_RD >= 1 && T_WR >= 1 && T_EXT >= 0) else $error("bad data strobe length");
   end

   xbus_phase_e       phase;
   logic              last;
   logic              start;
   logic [ADDR_W-1:0] h_addr;
   logic [PORT_W-1:0] h_wdata;
   logic              h_write, h_dmem, h_ext;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;
   assign rsp_done  = (phase == PH_REC) && last;

   xbus_req_hold #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(start),
      .in_addr(req_addr), .in_wdata(req_wdata), .in_write(req_write),
      .in_dmem(req_dmem), .in_ext(req_ext),
      .h_addr(h_addr), .h_wdata(h_wdata), .h_write(h_write),
      .h_dmem(h_dmem), .h_ext(h_ext));

   xbus_seq #(.T_SETUP(T_SETUP), .T_ASLO(T_ASLO), .T_FLOAT(T_FLOAT), .T_RD(T_RD),
              .T_WR(T_WR), .T_EXT(T_EXT), .T_REC(T_REC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(h_write),
      .is_ext(h_ext), .phase(phase), .last(last));

   xbus_pins #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .DM_ACTIVE_LOW(DM_ACTIVE_LOW)) u_pins (
      .phase(phase), .h_addr(h_addr), .h_wdata(h_wdata), .h_write(h_write),
      .h_dmem(h_dmem), .ad_out(bus_ad_out), .ad_oe(bus_ad_oe),
      .addr_hi(bus_addr_hi), .as_n(bus_as_n), .ds_n(bus_ds_n),
      .rw(bus_rw), .dm_sel(bus_dm_n));

   xbus_capture #(.PORT_W(PORT_W)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .grab((phase == PH_DATA) && last && !h_write),
      .din(bus_ad_in), .dout(rsp_rdata));

   // R1: an idle bus is quiet
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_as_n && bus_ds_n && !bus_ad_oe && !rsp_done));
   // R3: a read never drives the port while the data strobe is low
   assert_read_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ds_n && bus_rw) |-> !bus_ad_oe);
   // R4: a write drives the port for the whole data strobe
   assert_write_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ds_n && !bus_rw) |-> bus_ad_oe);
   // R7: direction line frozen inside a cycle
   assert_rw_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(bus_rw));
   // R8: memory select frozen inside a cycle
   assert_dm_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(bus_dm_n));
   // R9: done is a single pulse followed by idle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready));
endmodule

// File: tb/xbus_master_tb_top.sv
module xbus_master_tb_top;
   localparam int ADDR_W = 12;
   localparam int PORT_W = 8;
   localparam int HI_W   = ADDR_W - PORT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [PORT_W-1:0] req_wdata = '0;
   logic              req_write = 1'b0;
   logic              req_dmem = 1'b0;
   logic              req_ext = 1'b0;
   logic [PORT_W-1:0] rsp_rdata;
   logic              rsp_done;
   logic [PORT_W-1:0] bus_ad_out;
   logic              bus_ad_oe;
   logic [PORT_W-1:0] bus_ad_in = '0;
   logic [HI_W-1:0]   bus_addr_hi;
   logic              bus_as_n, bus_ds_n, bus_rw, bus_dm_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   xbus_master #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
      .req_dmem(req_dmem), .req_ext(req_ext), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
      .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi), .bus_as_n(bus_as_n),
      .bus_ds_n(bus_ds_n), .bus_rw(bus_rw), .bus_dm_n(bus_dm_n));

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic int data_len(input logic wr, input logic ext);
      return (wr ? 2 : 3) + (ext ? 2 : 0);
   endfunction

   function automatic logic [PORT_W-1:0] in_pat(input logic [PORT_W-1:0] seed, input int k);
      return seed ^ PORT_W'(k * 37);
   endfunction

   task automatic run_txn(input logic [ADDR_W-1:0] a, input logic [PORT_W-1:0] wd,
                          input logic wr, input logic dm, input logic ext, input logic poke);
      int len;
      int n;
      logic [PORT_W-1:0] seed;
      string ds_tag;
      len  = data_len(wr, ext);
      n    = 4 + len;
      seed = PORT_W'($urandom);
      ds_tag = ext ? "R6 ds_n" : (wr ? "R4 ds_n" : "R5 ds_n");
      @(negedge clk);
      check("R9 ready before request", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_addr = a; req_wdata = wd;
      req_write = wr; req_dmem = dm; req_ext = ext;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         bus_ad_in = in_pat(seed, k);
         if (poke && k < n) begin
            req_valid = 1'b1; req_addr = ADDR_W'($urandom); req_wdata = PORT_W'($urandom);
            req_write = !wr; req_dmem = !dm; req_ext = !ext;
         end else begin
            req_valid = 1'b0;
         end
         check("R9 ready busy", 32'(req_ready), 32'd0);
         check("R2 as_n", 32'(bus_as_n), 32'(k != 2));
         check(ds_tag, 32'(bus_ds_n), 32'(!(k >= 4 && k <= 3 + len)));
         check("R3 oe", 32'(bus_ad_oe), 32'(k <= 2 || (wr && k >= 3)));
         if (k <= 2)
            check("R2 address byte", 32'(bus_ad_out), 32'(a[PORT_W-1:0]));
         else if (wr)
            check("R4 write data", 32'(bus_ad_out), 32'(wd));
         check("R7 rw", 32'(bus_rw), 32'(!wr));
         check("R8 dm_n", 32'(bus_dm_n), 32'(!dm));
         check("R10 addr_hi", 32'(bus_addr_hi), 32'(a[ADDR_W-1:PORT_W]));
         check("R9 done", 32'(rsp_done), 32'(k == n));
         if (k == n && !wr)
            check("R5 read data", 32'(rsp_rdata), 32'(in_pat(seed, 3 + len)));
      end
      @(negedge clk);
      check("R9 idle after done", 32'(req_ready), 32'd1);
      check("R1 idle as_n", 32'(bus_as_n), 32'd1);
      check("R1 idle ds_n", 32'(bus_ds_n), 32'd1);
      check("R1 idle oe", 32'(bus_ad_oe), 32'd0);
      check("R8 idle dm_n", 32'(bus_dm_n), 32'd1);
   endtask

   initial begin
      int dummy;
      dummy = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      check("R1 reset as_n", 32'(bus_as_n), 32'd1);
      check("R1 reset ds_n", 32'(bus_ds_n), 32'd1);
      check("R1 reset oe", 32'(bus_ad_oe), 32'd0);
      check("R1 reset ready", 32'(req_ready), 32'd1);
      check("R1 reset done", 32'(rsp_done), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle no request", 32'(bus_as_n & bus_ds_n), 32'd1);
      // directed corners
      run_txn(12'hA5C, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
      run_txn(12'h3F0, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0);
      run_txn(12'hFFF, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
      run_txn(12'h001, 8'h7E, 1'b1, 1'b0, 1'b1, 1'b0);
      run_txn(12'h555, 8'hAA, 1'b1, 1'b1, 1'b0, 1'b1);
      run_txn(12'hAAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1);
      // constrained random
      for (int i = 0; i < 300; i++) begin
         run_txn(ADDR_W'($urandom), PORT_W'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom % 4) == 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule